// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a small bank of address windows. Each window is placed in a 32-bit address space by a base value and a size mask. It carries a target identifier and an attribute code, and it has an enable bit. Every lookup address is compared against all windows in parallel. One cycle later the block returns whether a window matched, the target and attribute of that window, and its index.

Window sizes come in 64 KB steps. The size mask is a run of ones that starts at bit 0. With N ones the window spans 2^N blocks of 64 KB, so a mask of zero still covers 64 KB. A mask with a gap in it is malformed. Writing one sets an error flag that stays set, and the window takes no part in decoding until a well-formed size is written to it. The windows are configured through one register port that both writes and reads. After reset, every window is disabled and its size register holds a default span.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, every window is disabled with base 0, target 0, attribute 0 and its error flag clear, and `res_valid`, `res_hit` and `res_miss` are 0. The size registers of windows 0 to 5 reset to 0x0FFF, 0x0000, 0x07FF, 0x07FF, 0x07FF and 0x0000, which are 256 MB, 64 KB, 128 MB, 128 MB, 128 MB and 64 KB.
- R2: A window hits when it is enabled, its error flag is clear, and `lk_addr[31:16] & ~size` equals `base & ~size`. The result returns the target, the attribute and the window index.
- R3: A size of 0x0000 covers exactly one 64 KB block. A mask of k ones covers 2^k blocks that start on a boundary of the same size.
- R4: When more than one window hits, the window with the lowest index wins.
- R5: A lookup that hits no window sets `res_miss`, clears `res_hit`, and drives target, attribute and index to 0. `res_hit` and `res_miss` are never 1 together.
- R6: A size write whose low 16 bits are not a run of ones from bit 0 followed only by zeros sets that window's error flag. While the flag is set, the window never hits. A later well-formed size write to the window clears the flag. `cfg_err` is the OR of all the flags.
- R7: A register write changes decoding from the cycle after the write. A lookup in the same cycle as the write still sees the old setting.
- R8: Results appear one clock after `lk_valid`, and `res_valid` follows `lk_valid` with that one-cycle delay. In idle cycles `res_hit` and `res_miss` are 0, and target, attribute and index keep their last values.
- R9: The register port is selected by `cfg_field`: 0 is the base, written from and read on data bits 31:16; 1 is the size, on bits 15:0; 2 is control, with bit 0 enable, bit 1 error flag (read only), bits 11:8 target and bits 23:16 attribute. Field 3 and window indices of 6 or more ignore writes and read as 0. Reads are combinational from the current register values.
- R10: A window whose enable bit is 0 never hits, whatever its base and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for the register access |
| cfg_field | input | 2 | Register field select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected window and field |
| cfg_err | output | 1 | At least one window holds a malformed size |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | A window matched |
| res_miss | output | 1 | No window matched |
| res_tgt | output | 4 | Target identifier of the winning window |
| res_attr | output | 8 | Attribute code of the winning window |
| res_idx | output | 3 | Index of the winning window |

## Verification
The assertions check four things on every cycle. A result follows its request by exactly one cycle. Hit and miss are exclusive and both stay low when no result is valid. A miss drives zero target, attribute and index. A malformed size write always raises the error flag. The bench scenarios cover what the assertions cannot. These are the reset spans of the size registers, the masked comparison at window edges and at 64 KB granularity, lowest-index priority across overlapping windows, and a write followed by a lookup in the same cycle. They also cover clearing the error with a well-formed rewrite and the writes that must be ignored.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

  localparam int ADDR_W = 32;
  localparam int PAGE_W = 16;   // address bits above the 64 KB block offset
  localparam int SZ_W   = 16;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  // One mask bit per halving of the byte span above 64 KB, capped at SZ_W bits.
  function automatic logic [SZ_W-1:0] bytes_to_size(input logic [ADDR_W-1:0] bytes);
    logic [ADDR_W-1:0] v;
    logic [SZ_W-1:0]   code;
    v    = bytes >> 1;
    code = '0;
    for (int i = 0; i < SZ_W; i++) begin
      if (v >= 32'h0001_0000) begin
        code[i] = 1'b1;
        v       = v >> 1;
      end
    end
    return code;
  endfunction

  // A mask is well formed when adding one carries through all its ones.
  function automatic logic size_ok(input logic [SZ_W-1:0] s);
    logic [SZ_W:0] e;
    e = {1'b0, s};
    return ((e & (e + {{SZ_W{1'b0}}, 1'b1})) == '0);
  endfunction

  // Span of each window after reset.
  function automatic logic [ADDR_W-1:0] boot_bytes(input int w);
    case (w)
      0:       return 32'h1000_0000;
      2, 3, 4: return 32'h0800_0000;
      default: return 32'h0001_0000;
    endcase
  endfunction

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_win,
  input  logic [1:0]                        cfg_field,
  input  logic [31:0]                       cfg_wdata,
  output logic [31:0]                       cfg_rdata,
  output logic                              cfg_err,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]    win_base,
  output logic [NUM_WIN-1:0][SZ_W-1:0]      win_size,
  output logic [NUM_WIN-1:0][TGT_W-1:0]     win_tgt,
  output logic [NUM_WIN-1:0][ATTR_W-1:0]    win_attr,
  output logic [NUM_WIN-1:0]                win_live
);

  fld_e               fld;
  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_bad;

  assign fld = fld_e'(cfg_field);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              sel;
    logic              base_ce, size_ce, ctrl_ce;
    logic [PAGE_W-1:0] base_d, base_q;
    logic [SZ_W-1:0]   size_d, size_q;
    logic [TGT_W-1:0]  tgt_d, tgt_q;
    logic [ATTR_W-1:0] attr_d, attr_q;
    logic              en_d, en_q;
    logic              bad_d, bad_q;

    assign sel     = cfg_we && (cfg_win == IDX_W'(w));
    assign base_ce = sel && (fld == FLD_BASE);
    assign size_ce = sel && (fld == FLD_SIZE);
    assign ctrl_ce = sel && (fld == FLD_CTRL);

    always_comb begin
      base_d = base_q;
      size_d = size_q;
      bad_d  = bad_q;
      tgt_d  = tgt_q;
      attr_d = attr_q;
      en_d   = en_q;
      if (base_ce) begin
        base_d = cfg_wdata[31:16];
      end
      if (size_ce) begin
        size_d = cfg_wdata[SZ_W-1:0];
        bad_d  = !size_ok(cfg_wdata[SZ_W-1:0]);
      end
      if (ctrl_ce) begin
        en_d   = cfg_wdata[0];
        tgt_d  = cfg_wdata[8 +: TGT_W];
        attr_d = cfg_wdata[16 +: ATTR_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        size_q <= bytes_to_size(boot_bytes(w));
        bad_q  <= 1'b0;
        tgt_q  <= '0;
        attr_q <= '0;
        en_q   <= 1'b0;
      end else begin
        base_q <= base_d;
        size_q <= size_d;
        bad_q  <= bad_d;
        tgt_q  <= tgt_d;
        attr_q <= attr_d;
        en_q   <= en_d;
      end
    end

    assign win_base[w] = base_q;
    assign win_size[w] = size_q;
    assign win_tgt[w]  = tgt_q;
    assign win_attr[w] = attr_q;
    assign win_en[w]   = en_q;
    assign win_bad[w]  = bad_q;
  end

  assign win_live = win_en & ~win_bad;
  assign cfg_err  = |win_bad;

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (cfg_win == IDX_W'(w)) begin
        case (fld)
          FLD_BASE: cfg_rdata[31:16] = win_base[w];
          FLD_SIZE: cfg_rdata[SZ_W-1:0] = win_size[w];
          FLD_CTRL: begin
            cfg_rdata[0]              = win_en[w];
            cfg_rdata[1]              = win_bad[w];
            cfg_rdata[8 +: TGT_W]     = win_tgt[w];
            cfg_rdata[16 +: ATTR_W]   = win_attr[w];
          end
          default: cfg_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/awd_match.sv
module awd_match
  import addr_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] base,
  input  logic [SZ_W-1:0]   size,
  input  logic              live,
  output logic              hit
);

  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] diff;

  // Compare only the block-number bits that the size mask does not free.
  assign keep = {~size, {(ADDR_W-PAGE_W){1'b0}}};
  assign diff = addr ^ {base, {(ADDR_W-PAGE_W){1'b0}}};
  assign hit  = live && ((diff & keep) == '0);

endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  assign any = |hits;

  always_comb begin
    idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hits[w]) begin
        idx = IDX_W'(w);
      end
    end
  end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter  int NUM_WIN = 6,
  parameter  int TGT_W   = 4,
  parameter  int ATTR_W  = 8,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_err,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [TGT_W-1:0]  res_tgt,
  output logic [ATTR_W-1:0] res_attr,
  output logic [IDX_W-1:0]  res_idx
);

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_WIN-1:0][PAGE_W-1:0] win_base;
  logic [NUM_WIN-1:0][SZ_W-1:0]   win_size;
  logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt;
  logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr;
  logic [NUM_WIN-1:0]             win_live;
  logic [NUM_WIN-1:0]             win_hit;

  awd_regfile #(
    .NUM_WIN (NUM_WIN),
    .TGT_W   (TGT_W),
    .ATTR_W  (ATTR_W),
    .IDX_W   (IDX_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_win   (cfg_win),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_err   (cfg_err),
    .win_base  (win_base),
    .win_size  (win_size),
    .win_tgt   (win_tgt),
    .win_attr  (win_attr),
    .win_live  (win_live)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    awd_match i_match (
      .addr (lk_addr),
      .base (win_base[w]),
      .size (win_size[w]),
      .live (win_live[w]),
      .hit  (win_hit[w])
    );
  end

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  awd_prio #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W)
  ) i_prio (
    .hits (win_hit),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  logic [TGT_W-1:0]  pick_tgt;
  logic [ATTR_W-1:0] pick_attr;

  always_comb begin
    pick_tgt  = '0;
    pick_attr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (pick_any && (pick_idx == IDX_W'(w))) begin
        pick_tgt  = win_tgt[w];
        pick_attr = win_attr[w];
      end
    end
  end

  // Result stage: next state, then registers.
  logic              valid_d, hit_d, miss_d;
  logic              data_ce;
  logic [TGT_W-1:0]  tgt_d;
  logic [ATTR_W-1:0] attr_d;
  logic [IDX_W-1:0]  idx_d;

  assign data_ce = lk_valid;

  always_comb begin
    valid_d = lk_valid;
    hit_d   = lk_valid && pick_any;
    miss_d  = lk_valid && !pick_any;
    tgt_d   = res_tgt;
    attr_d  = res_attr;
    idx_d   = res_idx;
    if (data_ce) begin
      tgt_d  = pick_tgt;
      attr_d = pick_attr;
      idx_d  = pick_any ? pick_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_tgt   <= '0;
      res_attr  <= '0;
      res_idx   <= '0;
    end else begin
      res_valid <= valid_d;
      res_hit   <= hit_d;
      res_miss  <= miss_d;
      res_tgt   <= tgt_d;
      res_attr  <= attr_d;
      res_idx   <= idx_d;
    end
  end

endmodule

// File: rtl/awd_checker.sv
module awd_checker
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  parameter int IDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_win,
  input logic [1:0]        cfg_field,
  input logic [SZ_W-1:0]   cfg_size,
  input logic              cfg_err,
  input logic              lk_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_miss,
  input logic [TGT_W-1:0]  res_tgt,
  input logic [ATTR_W-1:0] res_attr,
  input logic [IDX_W-1:0]  res_idx
);

  // R8: a request yields a valid result on the next cycle
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R8: no request, no result
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  // R8: flags stay low while no result is valid
  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_miss));

  // R5: hit and miss are exclusive
  p_hit_miss_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_hit && res_miss));

  // R5: a miss carries zero target, attribute and index
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_tgt == '0 && res_attr == '0 && res_idx == '0));

  // R4: the winning index names a real window
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (int'(res_idx) < NUM_WIN));

  // R6: a malformed size write raises the error flag
  p_bad_size_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 2'd1 && (int'(cfg_win) < NUM_WIN) && !size_ok(cfg_size))
    |=> cfg_err);

endmodule

bind addr_win_decoder awd_checker #(
  .NUM_WIN (NUM_WIN),
  .TGT_W   (TGT_W),
  .ATTR_W  (ATTR_W),
  .IDX_W   (IDX_W)
) i_awd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_win   (cfg_win),
  .cfg_field (cfg_field),
  .cfg_size  (cfg_wdata[15:0]),
  .cfg_err   (cfg_err),
  .lk_valid  (lk_valid),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_miss  (res_miss),
  .res_tgt   (res_tgt),
  .res_attr  (res_attr),
  .res_idx   (res_idx)
);

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_win;
  logic [1:0]  cfg_field;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        res_valid, res_hit, res_miss;
  logic [3:0]  res_tgt;
  logic [7:0]  res_attr;
  logic [2:0]  res_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_win_decoder i_addr_win_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_tgt(res_tgt), .res_attr(res_attr), .res_idx(res_idx)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_base [NW];
  logic [15:0] m_size [NW];
  bit          m_en   [NW];
  bit          m_bad  [NW];
  logic [3:0]  m_tgt  [NW];
  logic [7:0]  m_attr [NW];
  bit          e_valid, e_hit, e_miss;
  logic [3:0]  e_tgt;
  logic [7:0]  e_attr;
  logic [2:0]  e_idx;

  function automatic logic [15:0] dflt_size(int w);
    case (w)
      0: return 16'h0FFF;
      2, 3, 4: return 16'h07FF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit m_size_ok(logic [15:0] s);
    bit seen_zero = 0;
    for (int i = 0; i < 16; i++) begin
      if (!s[i]) seen_zero = 1;
      else if (seen_zero) return 0;
    end
    return 1;
  endfunction

  function automatic int m_find(logic [31:0] a);
    for (int w = 0; w < NW; w++) begin
      if (m_en[w] && !m_bad[w] &&
          ((a[31:16] & ~m_size[w]) == (m_base[w] & ~m_size[w])))
        return w;
    end
    return -1;
  endfunction

  function automatic logic [31:0] m_rdata(logic [2:0] w, logic [1:0] f);
    if (int'(w) >= NW) return 32'h0;
    case (f)
      2'd0: return {m_base[w], 16'h0};
      2'd1: return {16'h0, m_size[w]};
      2'd2: return {8'h0, m_attr[w], 4'h0, m_tgt[w], 6'h0, m_bad[w], m_en[w]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_any_bad();
    for (int w = 0; w < NW; w++) if (m_bad[w]) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int f;
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) begin
        m_base[w] = '0; m_size[w] = dflt_size(w); m_en[w] = 0;
        m_bad[w] = 0; m_tgt[w] = '0; m_attr[w] = '0;
      end
      e_valid = 0; e_hit = 0; e_miss = 0; e_tgt = '0; e_attr = '0; e_idx = '0;
    end else begin
      e_valid = lk_valid;
      e_hit   = 0;
      e_miss  = 0;
      if (lk_valid) begin
        f = m_find(lk_addr);
        e_hit  = (f >= 0);
        e_miss = (f < 0);
        e_tgt  = (f >= 0) ? m_tgt[f]  : 4'h0;
        e_attr = (f >= 0) ? m_attr[f] : 8'h0;
        e_idx  = (f >= 0) ? 3'(f)     : 3'h0;
      end
      if (cfg_we && int'(cfg_win) < NW) begin
        case (cfg_field)
          2'd0: m_base[cfg_win] = cfg_wdata[31:16];
          2'd1: begin
            m_size[cfg_win] = cfg_wdata[15:0];
            m_bad[cfg_win]  = !m_size_ok(cfg_wdata[15:0]);
          end
          2'd2: begin
            m_en[cfg_win]   = cfg_wdata[0];
            m_tgt[cfg_win]  = cfg_wdata[11:8];
            m_attr[cfg_win] = cfg_wdata[23:16];
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_req = "R1";

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp("res_valid", 32'(res_valid), 32'(e_valid));
    cmp("res_hit",   32'(res_hit),   32'(e_hit));
    cmp("res_miss",  32'(res_miss),  32'(e_miss));
    cmp("res_tgt",   32'(res_tgt),   32'(e_tgt));
    cmp("res_attr",  32'(res_attr),  32'(e_attr));
    cmp("res_idx",   32'(res_idx),   32'(e_idx));
    cmp("cfg_err",   32'(cfg_err),   32'(m_any_bad()));
    cmp("cfg_rdata", cfg_rdata, m_rdata(cfg_win, cfg_field));
  endtask

  task automatic cyc();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(int w, int f, logic [31:0] d);
    cfg_we = 1; cfg_win = 3'(w); cfg_field = 2'(f); cfg_wdata = d;
    cyc();
    cfg_we = 0;
  endtask

  task automatic rd(int w, int f);
    cfg_win = 3'(w); cfg_field = 2'(f);
    cyc();
  endtask

  task automatic look(logic [31:0] a);
    lk_valid = 1; lk_addr = a;
    cyc();
    lk_valid = 0;
  endtask

  function automatic logic [31:0] ctrl(bit en, logic [3:0] t, logic [7:0] a);
    return {8'h0, a, 4'h0, t, 7'h0, en};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_win = 0; cfg_field = 0; cfg_wdata = 0;
    lk_valid = 0; lk_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state, default spans, windows disabled
    cur_req = "R1";
    check_all();
    for (int w = 0; w < NW; w++) begin
      rd(w, 1);
      cmp("reset size", cfg_rdata, {16'h0, dflt_size(w)});
      rd(w, 2);
      cmp("reset ctrl", cfg_rdata, 32'h0);
    end
    look(32'h0000_0000);   // everything disabled: miss

    // R9: program windows, read back fields
    cur_req = "R9";
    wr(0, 0, 32'h8000_0000); wr(0, 1, 32'h0000_0FFF); wr(0, 2, ctrl(1, 4'h1, 8'hE8));
    wr(1, 0, 32'h9000_0000); wr(1, 1, 32'h0000_0000); wr(1, 2, ctrl(1, 4'h2, 8'h11));
    wr(2, 0, 32'h8000_0000); wr(2, 1, 32'h0000_00FF); wr(2, 2, ctrl(1, 4'h3, 8'h22));
    wr(3, 0, 32'h8000_0000); wr(3, 1, 32'h0000_0FFF); wr(3, 2, ctrl(1, 4'h4, 8'h33));
    wr(5, 0, 32'hA000_0000); wr(5, 1, 32'h0000_07FF); wr(5, 2, ctrl(1, 4'h6, 8'h55));
    rd(0, 2);
    cmp("ctrl readback w0", cfg_rdata, 32'h00E8_0101);
    rd(5, 0);
    cmp("base readback w5", cfg_rdata, 32'hA000_0000);

    // R2: masked hits inside windows
    cur_req = "R2";
    look(32'h8000_0000);
    cmp("hit idx", 32'(res_idx), 32'd0);
    look(32'h8FFF_FFFC);
    look(32'hA7FF_0000);
    cmp("w5 tgt", 32'(res_tgt), 32'h6);

    // R5: miss outputs
    cur_req = "R5";
    look(32'hA800_0000);
    cmp("miss flag", 32'(res_miss), 32'd1);
    look(32'h0000_0000);

    // R8: idle cycles after a lookup
    cur_req = "R8";
    look(32'h9000_0004);
    cyc();
    cmp("idle valid", 32'(res_valid), 32'd0);
    cyc();

    // R3: 64 KB window edges
    cur_req = "R3";
    look(32'h9000_0000);
    look(32'h9000_FFFF);
    cmp("64K top hit", 32'(res_idx), 32'd1);
    look(32'h9001_0000);
    cmp("64K past end", 32'(res_hit), 32'd0);
    look(32'h8FFF_FFFF);

    // R4: overlapping windows, lowest index wins
    cur_req = "R4";
    look(32'h8000_1234);
    cmp("w0 over w2/w3", 32'(res_idx), 32'd0);

    // R10: disabled window never hits
    cur_req = "R10";
    wr(0, 2, ctrl(0, 4'h1, 8'hE8));
    look(32'h8000_1234);
    cmp("w2 after w0 off", 32'(res_idx), 32'd2);
    look(32'h8500_0000);
    cmp("w3 outside w2", 32'(res_idx), 32'd3);
    wr(4, 0, 32'hC000_0000); wr(4, 1, 32'h0000_0000); wr(4, 2, ctrl(0, 4'h5, 8'h44));
    look(32'hC000_0000);
    cmp("disabled w4", 32'(res_hit), 32'd0);

    // R7: write and lookup in the same cycle
    cur_req = "R7";
    cfg_we = 1; cfg_win = 0; cfg_field = 2; cfg_wdata = ctrl(1, 4'h1, 8'hE8);
    lk_valid = 1; lk_addr = 32'h8000_0000;
    cyc();
    cfg_we = 0;
    cmp("same-cycle old cfg", 32'(res_idx), 32'd2);
    cyc();
    lk_valid = 0;
    cmp("next-cycle new cfg", 32'(res_idx), 32'd0);

    // R6: malformed sizes, sticky flag, clearing rewrite
    cur_req = "R6";
    wr(1, 1, 32'h0000_00F0);
    cmp("err set", 32'(cfg_err), 32'd1);
    look(32'h9000_0000);
    cmp("bad window silent", 32'(res_hit), 32'd0);
    rd(1, 2);
    cyc();
    cmp("err sticky", 32'(cfg_err), 32'd1);
    wr(1, 1, 32'h0000_0001);
    cmp("err cleared", 32'(cfg_err), 32'd0);
    look(32'h9001_0000);
    cmp("128K window", 32'(res_idx), 32'd1);
    wr(4, 1, 32'h0000_8000);
    wr(4, 2, ctrl(1, 4'h5, 8'h44));
    look(32'hC000_0000);
    wr(4, 1, 32'h0000_0003);
    look(32'hC003_0000);
    cmp("w4 256K", 32'(res_idx), 32'd4);

    // R9: ignored writes
    cur_req = "R9";
    wr(6, 2, ctrl(1, 4'hF, 8'hFF));
    wr(7, 0, 32'h0000_0000);
    wr(5, 3, 32'hFFFF_FFFF);
    rd(6, 2); rd(7, 0); rd(5, 3);
    cmp("reserved field", cfg_rdata, 32'h0);
    rd(5, 1);
    look(32'h0000_0000);

    // R2: mixed traffic
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) begin
        wr($urandom_range(0, 7), $urandom_range(0, 3),
           {4'h8 + 4'($urandom_range(0, 4)), 28'($urandom)} & 32'hFFFF_FFFF);
      end else if (r == 1) begin
        wr($urandom_range(0, 5), 1, 32'hFFFF >> $urandom_range(0, 16));
      end else if (r < 12) begin
        look({4'h8 + 4'($urandom_range(0, 4)), 28'($urandom)});
      end else begin
        rd($urandom_range(0, 7), $urandom_range(0, 3));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule